// File: doc/BRIEF.md
# SDRAM Row Timing Legality Checker

This block passively watches an SDRAM command bus (chip select, row strobe, column strobe, write enable, bank select, auto-precharge/all-banks bit and clock enable). It keeps a small state machine and a saturating cycle counter for each bank. It then reports any command that breaks the row timing rules. These rules are:

- read/write too soon after opening a row;
- opening rows in two different banks too close together;
- closing a row too early, or leaving it open too long;
- reopening a bank before its precharge has finished;
- opening a bank that is already open.

It also flags refresh, mode-set and power-down entry while any bank is not idle. Every limit is an integer cycle count given as a parameter, so the integrator rounds each time value up to whole clock periods.

Each rule drives its own output, which carries one bit per bank where the rule is bank-specific. A violation is a single-cycle pulse that appears in the cycle after the offending clock edge. An illegal command is still tracked as if the memory had executed it. The bank states are brought out for inspection.

Top module: `sdram_row_timing_chk`

## Requirements
- R1: After reset every bank reads idle, no violation output is high, and all timing windows count as already satisfied, so an activate in the first cycle after reset raises nothing.
- R2: With chip select low, row strobe low, column strobe high and write enable high, the command is an activate to the bank on `ba_i`. That bank's field of `bank_state_o` (bits [2b+1:2b]) becomes 1 (active) after that edge. Idle is 0 and precharging is 2.
- R3: A read (row strobe high, column strobe low, write enable high) or a write (same, but write enable low) is a violation on `viol_rcd_o[b]` in two cases: the target bank is not active, or fewer than `T_RCD` edges have passed since its activate.
- R4: An activate to a bank other than the previously activated one, fewer than `T_RRD` edges after that activate, pulses `viol_rrd_o`.
- R5: A precharge (row strobe and write enable low, column strobe high) to an active bank fewer than `T_RAS_MIN` edges after its activate pulses `viol_ras_min_o[b]`.
- R6: A bank that stays active for more than `T_RAS_MAX` edges pulses `viol_ras_max_o[b]` once. The pulse is high in the single cycle that begins `T_RAS_MAX`+1 edges after the activate edge.
- R7: A precharge with `ap_i` low closes only the bank on `ba_i`, while one with `ap_i` high closes every active bank. A closed bank reads 2 until `T_RP` edges after the precharge edge, and then reads 0.
- R8: An activate to a bank that is still precharging pulses `viol_rp_o[b]`.
- R9: An activate to a bank that is already active pulses `viol_act_o[b]`.
- R10: An auto/self refresh (row and column strobe low, write enable high), a mode set (all three low), or power-down entry (`cke_i` falling between two edges) pulses `viol_busy_o` while any bank is active or precharging. The same commands raise nothing when all banks are idle.
- R11: A violating command still takes effect: an early precharge still closes the row, and an early activate still opens it.
- R12: Any command sampled with chip select high has no effect on bank state or on any violation output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | BAW | Bank select |
| ap_i | input | 1 | Auto-precharge / all-banks address bit |
| cke_i | input | 1 | Clock enable |
| bank_state_o | output | 2*NB | Per-bank state, 2 bits each |
| viol_rcd_o | output | NB | Column access too early or to a closed bank |
| viol_rrd_o | output | 1 | Cross-bank activate spacing violated |
| viol_ras_min_o | output | NB | Row closed too early |
| viol_ras_max_o | output | NB | Row open too long |
| viol_rp_o | output | NB | Activate during precharge |
| viol_act_o | output | NB | Activate to an open bank |
| viol_busy_o | output | 1 | Global command while banks busy |

## Verification
A bank state that has drifted shows up on `bank_state_o` at the next sample after the edge that caused it. A wrong counter stays hidden until a command tests the matching limit: a count that is one off moves a violation pulse by one edge, or removes it. The bench therefore places each command exactly at the boundary of a window and one edge inside it, and compares every violation bit and the state word cycle by cycle. A busy flag that idles too early is caught by a refresh issued while a precharge is still running.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;
  typedef enum logic [1:0] {
    BK_IDLE   = 2'd0,
    BK_ACTIVE = 2'd1,
    BK_PRECH  = 2'd2
  } bank_st_e;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS, CMD_BST
  } cmd_e;
endpackage

// File: rtl/sdram_cmd_dec.sv
module sdram_cmd_dec
  import sdram_chk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  input  logic cke_i,
  output cmd_e cmd_o,
  output logic pd_entry_o
);
  logic cke_q;

  always_comb begin
    cmd_o = CMD_NOP;
    if (!cs_n_i) begin
      unique case ({ras_n_i, cas_n_i, we_n_i})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        3'b000:  cmd_o = CMD_MRS;
        3'b110:  cmd_o = CMD_BST;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b0;
    else         cke_q <= cke_i;
  end

  assign pd_entry_o = cke_q & ~cke_i;
endmodule

// File: rtl/sdram_rrd_track.sv
module sdram_rrd_track #(
  parameter int NB    = 4,
  parameter int T_RRD = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  act_i,
  input  logic [$clog2(NB)-1:0] ba_i,
  output logic                  viol_rrd_o
);
  localparam int BAW = $clog2(NB);
  localparam int CW  = $clog2(T_RRD + 1) + 1;

  logic [CW-1:0]  cnt_q;
  logic [BAW-1:0] last_q;
  logic           viol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '1;
      last_q <= '0;
      viol_q <= 1'b0;
    end else begin
      viol_q <= act_i && (ba_i != last_q) && (cnt_q < CW'(T_RRD));
      if (act_i) begin
        cnt_q  <= CW'(1);
        last_q <= ba_i;
      end else if (!(&cnt_q)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign viol_rrd_o = viol_q;

  assert_rrd_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_rrd_o |-> $past(act_i));
endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
  import sdram_chk_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RAS_MIN = 6,
  parameter int T_RAS_MAX = 40,
  parameter int T_RP      = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     act_i,
  input  logic     rw_i,
  input  logic     pre_i,
  output bank_st_e st_o,
  output logic     viol_rcd_o,
  output logic     viol_ras_min_o,
  output logic     viol_ras_max_o,
  output logic     viol_rp_o,
  output logic     viol_act_o
);
  // counter must pass T_RAS_MAX+1 without saturating there
  localparam int CW = $clog2(T_RAS_MAX + 3);

  bank_st_e      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic          rcd_q, min_q, max_q, rp_q, act_q;

  assign cnt_inc = (&cnt_q) ? cnt_q : cnt_q + 1'b1;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_inc;
    if (act_i) begin
      st_d  = BK_ACTIVE;
      cnt_d = CW'(1);
    end else if (pre_i && st_q == BK_ACTIVE) begin
      st_d  = (T_RP <= 1) ? BK_IDLE : BK_PRECH;
      cnt_d = CW'(1);
    end else if (st_q == BK_PRECH && cnt_inc >= CW'(T_RP)) begin
      st_d = BK_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= BK_IDLE;
      cnt_q <= '1;
      rcd_q <= 1'b0;
      min_q <= 1'b0;
      max_q <= 1'b0;
      rp_q  <= 1'b0;
      act_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      rcd_q <= rw_i && (st_q != BK_ACTIVE || cnt_q < CW'(T_RCD));
      min_q <= pre_i && st_q == BK_ACTIVE && cnt_q < CW'(T_RAS_MIN);
      max_q <= st_q == BK_ACTIVE && cnt_q == CW'(T_RAS_MAX + 1);
      rp_q  <= act_i && st_q == BK_PRECH;
      act_q <= act_i && st_q == BK_ACTIVE;
    end
  end

  assign st_o           = st_q;
  assign viol_rcd_o     = rcd_q;
  assign viol_ras_min_o = min_q;
  assign viol_ras_max_o = max_q;
  assign viol_rp_o      = rp_q;
  assign viol_act_o     = act_q;

  assert_act_opens_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> st_q == BK_ACTIVE);
  assert_prech_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == BK_PRECH |-> cnt_q < CW'(T_RP));
  assert_max_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_ras_max_o |=> !viol_ras_max_o);
  assert_early_pre_closes_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_ras_min_o |-> st_q != BK_ACTIVE || $past(act_i));
endmodule

// File: rtl/sdram_row_timing_chk.sv
module sdram_row_timing_chk
  import sdram_chk_pkg::*;
#(
  parameter int NB        = 4,
  parameter int T_RCD     = 3,
  parameter int T_RRD     = 2,
  parameter int T_RAS_MIN = 6,
  parameter int T_RAS_MAX = 40,
  parameter int T_RP      = 3,
  localparam int BAW      = $clog2(NB)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_n_i,
  input  logic            ras_n_i,
  input  logic            cas_n_i,
  input  logic            we_n_i,
  input  logic [BAW-1:0]  ba_i,
  input  logic            ap_i,
  input  logic            cke_i,
  output logic [2*NB-1:0] bank_state_o,
  output logic [NB-1:0]   viol_rcd_o,
  output logic            viol_rrd_o,
  output logic [NB-1:0]   viol_ras_min_o,
  output logic [NB-1:0]   viol_ras_max_o,
  output logic [NB-1:0]   viol_rp_o,
  output logic [NB-1:0]   viol_act_o,
  output logic            viol_busy_o
);
  cmd_e          cmd;
  logic          pd_entry, global_cmd, busy_q;
  logic [NB-1:0] act_v, rw_v, pre_v, busy_v;

  sdram_cmd_dec u_dec (
    .clk_i, .rst_ni, .cs_n_i, .ras_n_i, .cas_n_i, .we_n_i, .cke_i,
    .cmd_o(cmd), .pd_entry_o(pd_entry)
  );

  always_comb begin
    act_v = '0;
    rw_v  = '0;
    pre_v = '0;
    if (cmd == CMD_ACT) act_v[ba_i] = 1'b1;
    if (cmd == CMD_RD || cmd == CMD_WR) rw_v[ba_i] = 1'b1;
    if (cmd == CMD_PRE) begin
      if (ap_i) pre_v = '1;
      else      pre_v[ba_i] = 1'b1;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    bank_st_e st;
    sdram_bank_fsm #(
      .T_RCD(T_RCD), .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX), .T_RP(T_RP)
    ) u_bank (
      .clk_i, .rst_ni,
      .act_i(act_v[b]), .rw_i(rw_v[b]), .pre_i(pre_v[b]),
      .st_o(st),
      .viol_rcd_o(viol_rcd_o[b]),
      .viol_ras_min_o(viol_ras_min_o[b]),
      .viol_ras_max_o(viol_ras_max_o[b]),
      .viol_rp_o(viol_rp_o[b]),
      .viol_act_o(viol_act_o[b])
    );
    assign bank_state_o[2*b +: 2] = st;
    assign busy_v[b] = (st != BK_IDLE);
  end

  sdram_rrd_track #(.NB(NB), .T_RRD(T_RRD)) u_rrd (
    .clk_i, .rst_ni, .act_i(cmd == CMD_ACT), .ba_i, .viol_rrd_o
  );

  assign global_cmd = (cmd == CMD_REF) || (cmd == CMD_MRS) || pd_entry;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= global_cmd && (|busy_v);
  end
  assign viol_busy_o = busy_q;

  assert_single_act_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_v));
  assert_busy_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_busy_o |-> $past(global_cmd) && $past(|busy_v));
  assert_deselect_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> !viol_rcd_o && !viol_rrd_o && !viol_ras_min_o && !viol_rp_o && !viol_act_o);
endmodule

// File: tb/sim_sdram_row_timing_chk.sv
module sim_sdram_row_timing_chk;
  localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100, C_PRE = 3'b010,
                         C_REF = 3'b001, C_MRS = 3'b000, C_NOP = 3'b111;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_ni = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic       ap = 1'b0, cke = 1'b1;
  logic [7:0] st_o;
  logic [3:0] rcd_o, min_o, max_o, rp_o, act_o;
  logic       rrd_o, busy_o;

  sdram_row_timing_chk u0 (
    .clk_i(clk), .rst_ni, .cs_n_i(cs_n), .ras_n_i(ras_n), .cas_n_i(cas_n),
    .we_n_i(we_n), .ba_i(ba), .ap_i(ap), .cke_i(cke),
    .bank_state_o(st_o), .viol_rcd_o(rcd_o), .viol_rrd_o(rrd_o),
    .viol_ras_min_o(min_o), .viol_ras_max_o(max_o), .viol_rp_o(rp_o),
    .viol_act_o(act_o), .viol_busy_o(busy_o)
  );

  typedef struct {
    logic [21:0] viol;
    logic        chk_st;
    logic [7:0]  st;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [21:0] vbusy();          return 22'(1) << 21; endfunction
  function automatic logic [21:0] vrrd();           return 22'(1) << 20; endfunction
  function automatic logic [21:0] vact(int b);      return 22'(1) << (16 + b); endfunction
  function automatic logic [21:0] vrp(int b);       return 22'(1) << (12 + b); endfunction
  function automatic logic [21:0] vrcd(int b);      return 22'(1) << (8 + b); endfunction
  function automatic logic [21:0] vmin(int b);      return 22'(1) << (4 + b); endfunction
  function automatic logic [21:0] vmax(int b);      return 22'(1) << b; endfunction

  // monitor: pops one expectation per cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [21:0] got;
      it  = q.pop_front();
      got = {busy_o, rrd_o, act_o, rp_o, rcd_o, min_o, max_o};
      checks++;
      if (got !== it.viol) begin
        errors++;
        $display("FAIL %s viol got %h exp %h", it.req, got, it.viol);
      end
      if (it.chk_st) begin
        checks++;
        if (st_o !== it.st) begin
          errors++;
          $display("FAIL %s state got %h exp %h", it.req, st_o, it.st);
        end
      end
    end
  end

  task automatic step(input logic csn, input logic [2:0] rcw, input logic [1:0] b,
                      input logic a, input logic [21:0] ev, input logic chk,
                      input logic [7:0] est, input string req);
    item_t it;
    cs_n = csn; {ras_n, cas_n, we_n} = rcw; ba = b; ap = a;
    @(posedge clk);
    it.viol = ev; it.chk_st = chk; it.st = est; it.req = req;
    q.push_back(it);
    #1;
    cs_n = 1'b1; {ras_n, cas_n, we_n} = C_NOP; ap = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b1, C_NOP, 2'd0, 1'b0, '0, 1'b0, 8'h00, req);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; cke = 1'b1;
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state, timing satisfied
    step(1'b1, C_NOP, 0, 0, '0, 1, 8'h00, "R1 reset");
    step(1'b0, C_ACT, 0, 0, '0, 1, 8'h01, "R1 act after reset");
    step(1'b0, C_ACT, 2, 0, vrrd(), 1, 8'h11, "R4 rrd back-to-back");

    // R2/R3: activate then column access window
    do_reset();
    step(1'b0, C_ACT, 0, 0, '0, 1, 8'h01, "R2 activate");
    idle(1, "R3 wait");
    step(1'b0, C_RD, 0, 0, vrcd(0), 1, 8'h01, "R3 read early");
    step(1'b0, C_RD, 0, 0, '0, 1, 8'h01, "R3 read at limit");
    step(1'b0, C_WR, 0, 0, '0, 1, 8'h01, "R3 write ok");
    do_reset();
    step(1'b0, C_WR, 2, 0, vrcd(2), 1, 8'h00, "R3 write closed bank");

    // R4: spacing met
    do_reset();
    step(1'b0, C_ACT, 0, 0, '0, 1, 8'h01, "R4 first act");
    idle(1, "R4 wait");
    step(1'b0, C_ACT, 1, 0, '0, 1, 8'h05, "R4 spacing ok");

    // R5/R8/R11: early precharge still closes, early reopen still opens
    do_reset();
    step(1'b0, C_ACT, 1, 0, '0, 1, 8'h04, "R5 act");
    idle(3, "R5 wait");
    step(1'b0, C_PRE, 1, 0, vmin(1), 1, 8'h08, "R5 R11 early precharge");
    step(1'b0, C_ACT, 1, 0, vrp(1), 1, 8'h04, "R8 R11 act during precharge");

    // R7: legal close, precharge duration
    do_reset();
    step(1'b0, C_ACT, 3, 0, '0, 1, 8'h40, "R7 act");
    idle(5, "R7 wait");
    step(1'b0, C_PRE, 3, 0, '0, 1, 8'h80, "R7 precharge at limit");
    step(1'b1, C_NOP, 0, 0, '0, 1, 8'h80, "R7 still precharging");
    step(1'b1, C_NOP, 0, 0, '0, 1, 8'h00, "R7 idle after tRP");
    step(1'b0, C_ACT, 3, 0, '0, 1, 8'h40, "R7 reopen ok");

    // R7: all-bank precharge
    do_reset();
    step(1'b0, C_ACT, 0, 0, '0, 1, 8'h01, "R7 act b0");
    idle(1, "R7 wait");
    step(1'b0, C_ACT, 2, 0, '0, 1, 8'h11, "R7 act b2");
    idle(6, "R7 wait");
    step(1'b0, C_PRE, 0, 1, '0, 1, 8'h22, "R7 precharge all");

    // R9
    do_reset();
    step(1'b0, C_ACT, 2, 0, '0, 1, 8'h10, "R9 act");
    idle(2, "R9 wait");
    step(1'b0, C_ACT, 2, 0, vact(2), 1, 8'h10, "R9 act open bank");

    // R6
    do_reset();
    step(1'b0, C_ACT, 0, 0, '0, 1, 8'h01, "R6 act");
    idle(40, "R6 wait");
    step(1'b1, C_NOP, 0, 0, vmax(0), 1, 8'h01, "R6 row open too long");
    step(1'b1, C_NOP, 0, 0, '0, 1, 8'h01, "R6 single pulse");

    // R10
    do_reset();
    step(1'b0, C_ACT, 1, 0, '0, 1, 8'h04, "R10 act");
    step(1'b0, C_REF, 0, 0, vbusy(), 1, 8'h04, "R10 refresh while active");
    do_reset();
    step(1'b0, C_MRS, 0, 0, '0, 1, 8'h00, "R10 mode set idle");
    step(1'b0, C_REF, 0, 0, '0, 1, 8'h00, "R10 refresh idle");
    do_reset();
    step(1'b0, C_ACT, 1, 0, '0, 1, 8'h04, "R10 act");
    idle(5, "R10 wait");
    step(1'b0, C_PRE, 1, 0, '0, 1, 8'h08, "R10 precharge");
    step(1'b0, C_MRS, 0, 0, vbusy(), 1, 8'h08, "R10 mode set while precharging");
    do_reset();
    step(1'b0, C_ACT, 2, 0, '0, 1, 8'h10, "R10 act");
    cke = 1'b0;
    step(1'b1, C_NOP, 0, 0, vbusy(), 1, 8'h10, "R10 power-down while active");
    cke = 1'b1;

    // R12
    do_reset();
    step(1'b1, C_ACT, 0, 0, '0, 1, 8'h00, "R12 deselected act");
    step(1'b1, C_RD, 0, 0, '0, 1, 8'h00, "R12 deselected read");
    step(1'b0, C_RD, 0, 0, vrcd(0), 1, 8'h00, "R12 selected read");

    idle(2, "drain");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule